// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synchronous single-port memory whose command path accepts a read or a write on every enabled clock edge, in any mix and in any order, with no idle cycle between them. All inputs are registered on the rising edge. A read returns its word in the cycle right after the command edge. The read data flows combinationally out of the array from the registered address, so there is no output register. A write takes its data from the write-data input one cycle after the command, on the next enabled edge. Byte lanes are selected by active-low byte enables that are sampled with the command.

A short burst of four beats begins with a load cycle and goes on with continue cycles. The low two address bits step through the burst in an order chosen at build time: either interleaved (base XOR beat) or linear (base plus beat, wrapping within four). The read or write type is fixed by the load cycle. An active-low clock enable freezes the whole pipeline. A deselect cycle and a sleep input both stop the output drive, which is modelled here as an output-enable signal. The depth is a parameter. The full configuration uses a 16-bit address for 65,536 words of 32 bits. The default is smaller so that elaboration stays bounded.

Top module: `zbt_sram`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits, and both the lowest and the highest address store and return data on their own.
- R2: A load cycle with chip enable active (`ce_n`=0) and `we_n`=1 raises `oe` in the next cycle and puts the addressed word on `rdata` during that cycle.
- R3: A write load cycle (`we_n`=0) takes `wdata` on the next enabled edge. Lane i, bits 8i+7:8i, is written only when `be_n[i]`=0, and `be_n` all ones leaves the word unchanged. `oe` stays low in the cycle after a write command.
- R4: A command with `we_n`=1 is a read whatever the value of `be_n`, and it changes no stored word.
- R5: Reads and writes may alternate on consecutive edges. A read issued on the edge where the previous write's data is taken returns the merged new word.
- R6: While `cen_n`=1, nothing is sampled: `oe` and `rdata` hold, any pending write data waits for the next enabled edge, and the address and command inputs have no effect.
- R7: A load cycle with `ce_n`=1 deselects the block: `oe` is low in the next cycle and `rdata` reads zero. Continue cycles while deselected keep the block deselected.
- R8: A continue cycle (`adv_ld`=1) advances the low two address bits in burst order (XOR with the beat count when LINEAR_BURST=0, add with wrap when it is 1), keeps the upper bits, and keeps the load-time read/write type whatever `we_n` is.
- R9: While `zz`=1, all other inputs are ignored and `oe` is low. Afterwards the block is deselected until the next load.
- R10: A synchronous reset (`rst_n`=0) deselects the block, so that `oe`=0 and `rdata`=0. Memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the command pipeline |
| cen_n | input | 1 | Active-low clock enable; high stalls the block |
| ce_n | input | 1 | Active-low chip enable, sampled on load cycles |
| we_n | input | 1 | Active-low write enable, sampled on load cycles |
| adv_ld | input | 1 | 1 continues the burst, 0 loads a new address |
| be_n | input | DATA_W/8 | Active-low byte-lane write enables |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data, taken one enabled edge after its command |
| zz | input | 1 | Sleep: ignores other inputs and stops output drive |
| rdata | output | DATA_W | Flow-through read data, zero when oe is low |
| oe | output | 1 | High while rdata carries read data |

## Verification
Two situations are the hardest to reach from the ports. The first is a write whose data is due just as the pipeline is frozen or put to sleep. The second is a burst in which the continue cycles present the opposite write-enable level. The stimulus issues a write and then holds `cen_n` high while driving a wrong data word and a competing address, and only then releases the stall with the correct data. A burst write is followed by a burst read whose continue beats assert `we_n`, and a later read shows that no stray write landed. A sleep is entered with a write command on the pins, and the same address is read back afterwards.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        CMD_STALL = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_CONT  = 2'd2,
        CMD_SLEEP = 2'd3
    } cmd_e;

endpackage

// File: rtl/zbt_burst_addr.sv
module zbt_burst_addr #(
    parameter int ADDR_W = 10,
    parameter bit LINEAR = 1'b0
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        beat,
    output logic [ADDR_W-1:0] addr
);

    logic [1:0] low_bits;

    generate
        if (LINEAR) begin : g_linear
            assign low_bits = base[1:0] + beat;
        end else begin : g_interleave
            assign low_bits = base[1:0] ^ beat;
        end
    endgenerate

    assign addr = {base[ADDR_W-1:2], low_bits};

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4
) (
    input  logic                           clk,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           we,
    input  logic [LANES-1:0]               we_lane_n,
    input  logic [LANES*zbt_pkg::LANE_W-1:0] wdata,
    output logic [LANES*zbt_pkg::LANE_W-1:0] rdata
);
    import zbt_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] lane_mem [DEPTH];

            always_ff @(posedge clk) begin
                if (we && !we_lane_n[g]) begin
                    lane_mem[addr] <= wdata[g*LANE_W +: LANE_W];
                end
            end

            assign rdata[g*LANE_W +: LANE_W] = lane_mem[addr];
        end
    endgenerate

endmodule

// File: rtl/zbt_ctrl.sv
module zbt_ctrl #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter bit LINEAR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              adv_ld,
    input  logic              zz,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be_n,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              wr_en,
    output logic [LANES-1:0]  wr_lane_n,
    output logic              oe
);
    import zbt_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [ADDR_W-1:0] base;
        logic [1:0]        beat;
        logic [LANES-1:0]  lane_n;
    } state_t;

    state_t st_d, st_q;
    cmd_e   cmd;

    zbt_burst_addr #(
        .ADDR_W (ADDR_W),
        .LINEAR (LINEAR)
    ) u_burst (
        .base (st_q.base),
        .beat (st_q.beat),
        .addr (cur_addr)
    );

    always_comb begin
        if (zz) begin
            cmd = CMD_SLEEP;
        end else if (cen_n) begin
            cmd = CMD_STALL;
        end else if (adv_ld) begin
            cmd = CMD_CONT;
        end else begin
            cmd = CMD_LOAD;
        end

        st_d = st_q;
        unique case (cmd)
            CMD_SLEEP: begin
                st_d.valid = 1'b0;
            end
            CMD_LOAD: begin
                st_d.valid  = !ce_n;
                st_d.wr     = !we_n;
                st_d.base   = addr;
                st_d.beat   = 2'd0;
                st_d.lane_n = we_n ? '1 : be_n;
            end
            CMD_CONT: begin
                st_d.beat   = st_q.beat + 2'd1;
                st_d.lane_n = st_q.wr ? be_n : '1;
            end
            default: begin
            end
        endcase
    end

    // Write data for the registered write command is taken on the next enabled edge
    assign wr_en     = st_q.valid && st_q.wr && (cmd == CMD_LOAD || cmd == CMD_CONT);
    assign wr_lane_n = st_q.lane_n;
    assign oe        = st_q.valid && !st_q.wr && !zz;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (cen_n && !zz) |=> ($stable(st_q.valid) && $stable(st_q.wr) && $stable(cur_addr))); // R6

    AST_BURST_KEEPS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && !cen_n && adv_ld) |=> ($stable(st_q.wr)
            && cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]))); // R8

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 32,
    parameter bit LINEAR_BURST = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cen_n,
    input  logic                         ce_n,
    input  logic                         we_n,
    input  logic                         adv_ld,
    input  logic [DATA_W/8-1:0]          be_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         zz,
    output logic [DATA_W-1:0]            rdata,
    output logic                         oe
);
    import zbt_pkg::*;

    localparam int LANES = DATA_W / LANE_W;

    logic [ADDR_W-1:0] cur_addr;
    logic              wr_en;
    logic [LANES-1:0]  wr_lane_n;
    logic [DATA_W-1:0] arr_rdata;

    zbt_ctrl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LINEAR (LINEAR_BURST)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cen_n     (cen_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .adv_ld    (adv_ld),
        .zz        (zz),
        .addr      (addr),
        .be_n      (be_n),
        .cur_addr  (cur_addr),
        .wr_en     (wr_en),
        .wr_lane_n (wr_lane_n),
        .oe        (oe)
    );

    zbt_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_array (
        .clk       (clk),
        .addr      (cur_addr),
        .we        (wr_en),
        .we_lane_n (wr_lane_n),
        .wdata     (wdata),
        .rdata     (arr_rdata)
    );

    assign rdata = oe ? arr_rdata : '0;

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && !cen_n && !adv_ld && !ce_n && we_n) |=> (oe || zz)); // R2 R4

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && !cen_n && !adv_ld && !we_n) |=> !oe); // R3

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && !cen_n && !adv_ld && ce_n) |=> !oe); // R7

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        zz |=> !oe); // R9

endmodule

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;

    localparam int AW  = 10;
    localparam int DW  = 32;
    localparam int LN  = DW / 8;
    localparam bit LIN = 1'b0;

    logic          clk = 1'b0;
    logic          rst_n, cen_n, ce_n, we_n, adv_ld, zz;
    logic [LN-1:0] be_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic          oe;

    always #4 clk = ~clk;

    zbt_sram #(.ADDR_W(AW), .DATA_W(DW), .LINEAR_BURST(LIN)) dut (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce_n(ce_n), .we_n(we_n),
        .adv_ld(adv_ld), .be_n(be_n), .addr(addr), .wdata(wdata), .zz(zz),
        .rdata(rdata), .oe(oe)
    );

    typedef struct {
        logic          oe;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            total = 0;
    int            fails = 0;
    logic [DW-1:0] ref_m [int];

    // Bench-side model of the command pipeline
    logic          m_valid = 1'b0, m_wr = 1'b0, m_pw = 1'b0, last_oe = 1'b0;
    logic [AW-1:0] m_base = '0, m_pw_addr = '0;
    logic [1:0]    m_beat = '0;
    logic [LN-1:0] m_pw_be = '1;
    logic [DW-1:0] last_d = '0;

    function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, logic [1:0] c);
        logic [1:0] lo;
        lo = LIN ? (b[1:0] + c) : (b[1:0] ^ c);
        return {b[AW-1:2], lo};
    endfunction

    task automatic check(input logic got_oe, input logic [DW-1:0] got_d,
                         input logic e_oe, input logic [DW-1:0] e_d, input string tag);
        total++;
        if (got_oe !== e_oe || got_d !== e_d) begin
            fails++;
            $display("FAIL %s: oe=%0b rdata=%h expected oe=%0b rdata=%h",
                     tag, got_oe, got_d, e_oe, e_d);
        end
    endtask

    task automatic step(input logic c_n, input logic e_n, input logic w_n, input logic adv,
                        input logic [AW-1:0] a, input logic [LN-1:0] b,
                        input logic [DW-1:0] wd, input logic z, input string tag);
        exp_t          e;
        logic [AW-1:0] now_a;
        logic [DW-1:0] t;
        @(negedge clk);
        cen_n = c_n; ce_n = e_n; we_n = w_n; adv_ld = adv;
        addr = a; be_n = b; wdata = wd; zz = z;
        if (z) begin
            m_valid = 1'b0; m_pw = 1'b0; e.oe = 1'b0; e.d = '0;
        end else if (c_n) begin
            e.oe = last_oe; e.d = last_d;
        end else begin
            if (m_pw) begin
                t = ref_m.exists(int'(m_pw_addr)) ? ref_m[int'(m_pw_addr)] : 'x;
                for (int i = 0; i < LN; i++) if (!m_pw_be[i]) t[i*8 +: 8] = wd[i*8 +: 8];
                ref_m[int'(m_pw_addr)] = t;
            end
            m_pw = 1'b0;
            if (!adv) begin
                m_valid = !e_n; m_wr = !w_n; m_base = a; m_beat = 2'd0;
            end else begin
                m_beat = m_beat + 2'd1;
            end
            now_a = beat_addr(m_base, m_beat);
            if (m_valid && m_wr) begin
                m_pw = 1'b1; m_pw_addr = now_a; m_pw_be = b;
            end
            e.oe = m_valid && !m_wr;
            e.d  = e.oe ? ref_m[int'(now_a)] : '0;
        end
        last_oe = e.oe; last_d = e.d;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] wd, input string tag);
        step(1'b0, 1'b0, 1'b1, 1'b0, a, '1, wd, 1'b0, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [LN-1:0] b,
                      input logic [DW-1:0] wd, input string tag);
        step(1'b0, 1'b0, 1'b0, 1'b0, a, b, wd, 1'b0, tag);
    endtask

    task automatic cont(input logic w_n, input logic [LN-1:0] b,
                        input logic [DW-1:0] wd, input string tag);
        step(1'b0, 1'b0, w_n, 1'b1, '0, b, wd, 1'b0, tag);
    endtask

    task automatic stall(input logic [AW-1:0] a, input logic [DW-1:0] wd, input string tag);
        step(1'b1, 1'b0, 1'b0, 1'b0, a, '0, wd, 1'b0, tag);
    endtask

    // Monitor: compares each expected item one edge after its command
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(oe, rdata, e.oe, e.d, e.tag);
            end
        end
    end

    initial begin
        #(8 * 20000);
        total++;
        fails++;
        $display("FAIL watchdog: actual run still busy, expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cen_n = 1'b0; ce_n = 1'b0; we_n = 1'b1; adv_ld = 1'b0;
        zz = 1'b0; be_n = '1; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(oe, rdata, 1'b0, '0, "R10 reset state");

        // R5: read right after write, then alternation
        wr(10'h010, 4'b0000, 32'h0, "R5");
        rd(10'h010, 32'h1234_5678, "R5");
        rd(10'h010, 32'h0, "R2");
        wr(10'h011, 4'b0000, 32'h0, "R5");
        rd(10'h010, 32'h0B0B_0011, "R5");
        wr(10'h012, 4'b0000, 32'h0, "R5");
        rd(10'h011, 32'h0C0C_0012, "R5");
        rd(10'h012, 32'h0, "R5");

        // R3: byte lanes
        wr(10'h010, 4'b1010, 32'h0, "R3");
        rd(10'h010, 32'hAABB_CCDD, "R3");
        wr(10'h011, 4'b1111, 32'h0, "R3");
        rd(10'h011, 32'hFFFF_FFFF, "R3");
        wr(10'h012, 4'b0111, 32'h0, "R3");
        rd(10'h012, 32'h9900_0000, "R3");

        // R4: we_n high with all byte enables low is a read
        step(1'b0, 1'b0, 1'b1, 1'b0, 10'h011, 4'b0000, 32'h5555_5555, 1'b0, "R4");
        rd(10'h011, 32'h6666_6666, "R4");

        // R6: stalls hold output and delay write data capture
        rd(10'h010, 32'h0, "R6");
        stall(10'h012, 32'h0, "R6");
        stall(10'h011, 32'h0, "R6");
        rd(10'h012, 32'h0, "R6");
        wr(10'h013, 4'b0000, 32'h0, "R6");
        stall(10'h010, 32'hBAD0_BAD0, "R6");
        stall(10'h011, 32'hBAD1_BAD1, "R6");
        rd(10'h013, 32'h1313_1313, "R6");
        rd(10'h013, 32'h0, "R6");

        // R7: deselect and continue while deselected
        step(1'b0, 1'b1, 1'b1, 1'b0, 10'h010, '1, 32'h0, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b1, 1'b1, 10'h010, '1, 32'h0, 1'b0, "R7");
        rd(10'h010, 32'h0, "R7");

        // R8: burst write then burst read with we_n flipped on continue beats
        wr(10'h021, 4'b0000, 32'h0, "R8");
        cont(1'b1, 4'b0000, 32'hB000_0000, "R8");
        cont(1'b1, 4'b0000, 32'hB111_1111, "R8");
        cont(1'b1, 4'b0000, 32'hB222_2222, "R8");
        rd(10'h021, 32'hB333_3333, "R8");
        cont(1'b0, 4'b0000, 32'hEEEE_0001, "R8");
        cont(1'b0, 4'b0000, 32'hEEEE_0002, "R8");
        cont(1'b0, 4'b0000, 32'hEEEE_0003, "R8");
        rd(10'h020, 32'hEEEE_0004, "R8");
        rd(10'h021, 32'h0, "R8");

        // R9: sleep ignores a write and leaves the block deselected
        rd(10'h010, 32'h0, "R9");
        step(1'b0, 1'b0, 1'b0, 1'b0, 10'h010, 4'b0000, 32'h7777_7777, 1'b1, "R9");
        step(1'b0, 1'b0, 1'b0, 1'b0, 10'h010, 4'b0000, 32'h7777_7777, 1'b1, "R9");
        step(1'b0, 1'b0, 1'b1, 1'b1, 10'h000, '1, 32'h7777_7777, 1'b0, "R9");
        rd(10'h010, 32'h7777_7777, "R9");

        // R1: lowest and highest addresses
        wr(10'h3FF, 4'b0000, 32'h0, "R1");
        wr(10'h000, 4'b0000, 32'hF0F0_F0F0, "R1");
        rd(10'h3FF, 32'h0F0F_0F0F, "R1");
        rd(10'h000, 32'h0, "R1");
        rd(10'h3FF, 32'h0, "R1");

        // drain the scoreboard with deselects
        step(1'b0, 1'b1, 1'b1, 1'b0, 10'h000, '1, 32'h0, 1'b0, "R7");
        step(1'b0, 1'b1, 1'b1, 1'b0, 10'h000, '1, 32'h0, 1'b0, "R7");
        repeat (3) @(negedge clk);

        // R10: reset in the middle of a read stream
        rd(10'h010, 32'h0, "R10");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check(oe, rdata, 1'b0, '0, "R10 reset mid-run");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule